// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Pulse Measurement

This block is a single timer channel that works in one of three modes. As an interval timer it counts down once per tick enable. As an event counter it counts down once per chosen edge of an external input. In both of these modes it reloads from a reload register on underflow and raises an interrupt request. In measurement mode the counter counts up freely, once per tick. On every effective input edge the count is copied into a capture register and the counter restarts from zero. The effective edge is one polarity for period measurement and both polarities for width measurement.

Software drives the block through a small register port with a write strobe and a read strobe. The read data is registered and appears one cycle after the read strobe. The read-back of the count depends on timing: it returns all ones in the cycle in which the counter reloads. While the counter is halted, it returns a value just written. The input pin passes through a synchronizer before any edge is detected. The interrupt request is a sticky flag that software clears by writing zero to it.

Top module: `pulse_timer`

## Requirements
- R1: Address 0 write with the start bit clear loads both the reload register and the counter, so a following read of address 0 returns the written value.
- R2: In timer mode (control bits [1:0] = 0) with the start bit (control bit 4) set, the counter decrements by one per clock in which `tick_en` is high, and a read of address 0 returns the live count.
- R3: In timer or event mode, a decrement step taken at count zero loads the counter from the reload register instead and sets the interrupt flag.
- R4: A read of address 0 sampled in the same clock edge as a reload returns 16'hFFFF, not the reload value.
- R5: In event mode (control bits [1:0] = 1), the counter steps once per effective input edge and ignores `tick_en`. Control bit 3 selects the edge: 0 means rising, 1 means falling. The other polarity has no effect.
- R6: With the start bit clear, the counter holds its value whatever `tick_en` and the input do.
- R7: The interrupt flag (status address 2, bit 0, also driven on `irq`) stays set until a write of 0 to address 2. A write of 1 has no effect, and a set event in the same cycle as a clearing write leaves the flag set.
- R8: In measurement mode (control bits [1:0] = 2), the first effective edge after the start bit rises copies the count into the capture register (address 3) and clears the counter, without setting the interrupt flag.
- R9: Every later effective edge in measurement mode copies the count to the capture register, clears the counter and sets the interrupt flag. The counter counts up by one per tick. With control bit 2 clear (period) only the polarity from bit 3 is effective; with bit 2 set (width) both edges are.
- R10: While running in measurement mode, a control write that changes bit 2 sets the interrupt flag. A write that leaves bit 2 unchanged does not.
- R11: The input passes through two synchronizing flip-flops, so an input change first affects the counter on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick enable for timer and measurement modes |
| pin_in | input | 1 | Asynchronous external input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count/reload, 1 control, 2 status, 3 capture) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request flag |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a two-stage synchronizer. It keeps the reload values small and drives single ticks by hand, so every reload, the all-ones read at the reload edge and each capture land on a known clock edge. The two-stage synchronizer lets the bench check the exact edge on which an input change first moves the counter.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_EVENT   = 2'd1,
    MODE_MEASURE = 2'd2,
    MODE_IDLE    = 2'd3
  } mode_e;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT   = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAPTURE = 2'd3;

  localparam int unsigned CB_WIDTH = 2;
  localparam int unsigned CB_FALL  = 3;
  localparam int unsigned CB_START = 4;

  typedef struct packed {
    logic  start;
    logic  fall_pol;
    logic  width_sel;
    mode_e mode;
  } ctrl_t;

endpackage

// File: rtl/pulse_timer_edge.sv
module pulse_timer_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], pin_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pulse_timer_core.sv
module pulse_timer_core
  import pulse_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode,
  input  logic             run,
  input  logic             start_rise,
  input  logic             tick,
  input  logic             evt_edge,
  input  logic             meas_edge,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] capture_q,
  output logic             reload_now,
  output logic             meas_req
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic first_q;
  logic step;

  always_comb begin
    case (mode)
      MODE_TIMER: step = run & tick;
      MODE_EVENT: step = run & evt_edge;
      default:    step = 1'b0;
    endcase
  end

  assign reload_now = step & (count_q == '0);
  assign meas_req   = run & (mode == MODE_MEASURE) & meas_edge & ~first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
    end else if (load_wr) begin
      reload_q <= load_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      capture_q <= '0;
      first_q   <= 1'b0;
    end else begin
      if (start_rise) first_q <= 1'b1;
      if (!run) begin
        if (load_wr) count_q <= load_val;
      end else if (mode == MODE_MEASURE) begin
        if (meas_edge) begin
          capture_q <= count_q;
          count_q   <= '0;
          first_q   <= 1'b0;
        end else if (tick) begin
          count_q <= count_q + ONE;
        end
      end else if (step) begin
        count_q <= (count_q == '0) ? reload_q : count_q - ONE;
      end
    end
  end

endmodule

// File: rtl/pulse_timer_flag.sv
module pulse_timer_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);

  ctrl_t            ctrl_q;
  logic             rise, fall;
  logic             evt_edge, meas_edge;
  logic             wr_count, wr_ctrl, wr_status;
  logic             start_rise, mode_chg;
  logic             irq_set, irq_clr;
  logic [CNT_W-1:0] count_q, reload_q, capture_q;
  logic             reload_now, meas_req;
  logic [CNT_W-1:0] count_view;
  logic             run;

  assign wr_count  = wr_en & (wr_addr == A_COUNT);
  assign wr_ctrl   = wr_en & (wr_addr == A_CTRL);
  assign wr_status = wr_en & (wr_addr == A_STATUS);
  assign run       = ctrl_q.start;

  assign start_rise = wr_ctrl & wr_data[CB_START] & ~ctrl_q.start;
  assign mode_chg   = wr_ctrl & run & (ctrl_q.mode == MODE_MEASURE)
                    & (wr_data[CB_WIDTH] != ctrl_q.width_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.mode      <= mode_e'(wr_data[1:0]);
      ctrl_q.width_sel <= wr_data[CB_WIDTH];
      ctrl_q.fall_pol  <= wr_data[CB_FALL];
      ctrl_q.start     <= wr_data[CB_START];
    end
  end

  pulse_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .pin_async (pin_in),
    .rise      (rise),
    .fall      (fall)
  );

  assign evt_edge  = ctrl_q.fall_pol ? fall : rise;
  assign meas_edge = ctrl_q.width_sel ? (rise | fall) : evt_edge;

  pulse_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .mode       (ctrl_q.mode),
    .run        (run),
    .start_rise (start_rise),
    .tick       (tick_en),
    .evt_edge   (evt_edge),
    .meas_edge  (meas_edge),
    .load_wr    (wr_count),
    .load_val   (wr_data),
    .count_q    (count_q),
    .reload_q   (reload_q),
    .capture_q  (capture_q),
    .reload_now (reload_now),
    .meas_req   (meas_req)
  );

  assign irq_set = reload_now | meas_req | mode_chg;
  assign irq_clr = wr_status & ~wr_data[0];

  pulse_timer_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .flag_q (irq)
  );

  assign count_view = reload_now ? '1 : count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_COUNT:  rd_data <= count_view;
        A_CTRL:   rd_data <= CNT_W'(ctrl_q);
        A_STATUS: rd_data <= CNT_W'(irq);
        default:  rd_data <= capture_q;
      endcase
    end
  end

endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             wr_count,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             reload_now,
  input logic             rd_cnt,
  input logic [CNT_W-1:0] rd_data,
  input logic             irq,
  input logic             irq_set,
  input logic             irq_clr,
  input logic             mode_chg
);

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_count) |=> (count_q == $past(count_q))); // R6

  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
    reload_now |=> (count_q == $past(reload_q)) && irq); // R3

  AST_RELOAD_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (reload_now && rd_cnt) |=> (rd_data == '1)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (irq_set && irq_clr) |=> irq); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R7

  AST_MODE_CHANGE_REQ: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> irq); // R10

endmodule

bind pulse_timer pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run        (run),
  .wr_count   (wr_count),
  .count_q    (count_q),
  .reload_q   (reload_q),
  .reload_now (reload_now),
  .rd_cnt     (rd_en && (rd_addr == 2'd0)),
  .rd_data    (rd_data),
  .irq        (irq),
  .irq_set    (irq_set),
  .irq_clr    (irq_clr),
  .mode_chg   (mode_chg)
);

// File: tb/pulse_timer_tb.sv
module pulse_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        pin_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  pulse_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pin_in(pin_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk); pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R1 reset count", d, 16'h0000);
    rd(2'd1, d); check("R1 reset ctrl", d, 16'h0000);
    check("R7 reset irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic test_timer();
    logic [15:0] d;
    wr(2'd0, 16'd3);
    rd(2'd0, d); check("R1 halted write readback", d, 16'd3);
    wr(2'd1, 16'h0010);
    ticks(1);
    rd(2'd0, d); check("R2 live count", d, 16'd2);
    ticks(2);
    rd(2'd0, d); check("R2 count at zero", d, 16'd0);
    check("R3 no irq before underflow", {15'd0, irq}, 16'd0);
    @(negedge clk); tick_en = 1'b1; rd_en = 1'b1; rd_addr = 2'd0;
    @(negedge clk); tick_en = 1'b0; rd_en = 1'b0;
    check("R4 read at reload edge", rd_data, 16'hFFFF);
    check("R3 irq on underflow", {15'd0, irq}, 16'd1);
    rd(2'd0, d); check("R3 reloaded value", d, 16'd3);
    wr(2'd1, 16'h0000);
    ticks(3);
    rd(2'd0, d); check("R6 frozen when stopped", d, 16'd3);
    wr(2'd2, 16'd1);
    check("R7 write one keeps flag", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'd0);
    check("R7 write zero clears flag", {15'd0, irq}, 16'd0);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'h0010);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd0;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    check("R7 set wins over clear", {15'd0, irq}, 16'd1);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'd0);
  endtask

  task automatic test_event();
    logic [15:0] d;
    wr(2'd0, 16'd2);
    wr(2'd1, 16'h0011);
    ticks(3);
    rd(2'd0, d); check("R5 ticks ignored in event mode", d, 16'd2);
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk); rd_en = 1'b1; rd_addr = 2'd0;
    @(negedge clk);
    check("R11 no effect before third edge", rd_data, 16'd2);
    @(negedge clk); rd_en = 1'b0;
    check("R11 effect at third edge", rd_data, 16'd1);
    pin_set(1'b0);
    rd(2'd0, d); check("R5 falling edge ignored", d, 16'd1);
    pin_set(1'b1);
    rd(2'd0, d); check("R5 rising edge counts", d, 16'd0);
    pin_set(1'b0);
    pin_set(1'b1);
    check("R3 event underflow irq", {15'd0, irq}, 16'd1);
    rd(2'd0, d); check("R3 event reload", d, 16'd2);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'd0);
  endtask

  task automatic test_measure();
    logic [15:0] d;
    pin_set(1'b0);
    wr(2'd1, 16'h0012);
    ticks(5);
    rd(2'd0, d); check("R9 measure counts up", d, 16'd7);
    pin_set(1'b1);
    check("R8 first edge no irq", {15'd0, irq}, 16'd0);
    rd(2'd3, d); check("R8 first capture", d, 16'd7);
    rd(2'd0, d); check("R8 counter cleared", d, 16'd0);
    ticks(4);
    pin_set(1'b0);
    rd(2'd0, d); check("R9 period ignores other edge", d, 16'd4);
    check("R9 no irq on other edge", {15'd0, irq}, 16'd0);
    ticks(3);
    pin_set(1'b1);
    check("R9 later edge irq", {15'd0, irq}, 16'd1);
    rd(2'd3, d); check("R9 period capture", d, 16'd7);
    rd(2'd0, d); check("R9 counter cleared", d, 16'd0);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'h0016);
    check("R10 select change sets irq", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'h0016);
    check("R10 same select no irq", {15'd0, irq}, 16'd0);
    ticks(2);
    pin_set(1'b0);
    check("R9 width falling edge irq", {15'd0, irq}, 16'd1);
    rd(2'd3, d); check("R9 width capture", d, 16'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_timer();
    test_event();
    test_measure();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule